// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block sits beside a small 8-bit controller core. It decides at which instruction boundary a pending peripheral interrupt is taken, and then it runs the entry sequence. The core raises a one-cycle strobe each time an instruction retires. With that strobe it presents a two-bit class for the retiring instruction and the address of the next instruction, which is the return address. When the block accepts a request, it stalls the core for a fixed four-cycle entry. During those cycles it clears the global enable, acknowledges the winning source, emits the return address as two byte pushes and presents the vector slot address.

Three instruction classes turn the global enable on: a set-enable instruction, a return from a handler, and a status-register store that writes a 1 to the enable bit. An instruction of any of these classes never lets an interrupt be taken at its own retirement boundary. The instruction after it therefore always runs. If the enable is already on, a newly raised request is taken at the very next boundary, with no extra delay.

Top module: `irq_entry_seq`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, every output is zero.
- R2: A request is accepted only at a cycle where all of the following hold: `insn_done` is 1, `gie` is 1, `insn_cls` is 0 (plain), at least one `irq_req` bit is set, and no entry is in progress. `take` is 1 for exactly the single cycle after that boundary cycle.
- R3: A boundary whose `insn_cls` is 1 (set-enable) is never accepted, even with a request pending. The next boundary with class 0 is accepted.
- R4: A boundary whose `insn_cls` is 2 (return from handler) is never accepted. The next boundary with class 0 is accepted.
- R5: A boundary whose `insn_cls` is 3 (status store setting the enable bit) is never accepted. The next boundary with class 0 is accepted.
- R6: Back-to-back enabling instructions each block their own boundary, so the shadow restarts with each one.
- R7: With `gie` at 0, no request is accepted. Once `gie` is 1, a pending request is taken at the first class-0 boundary, with no extra instruction of delay.
- R8: The lowest-numbered set request wins. `vec_addr` equals VEC_BASE + index × SLOT_WORDS, is held through the entry, and is zero otherwise.
- R9: `stall` is high for exactly four cycles, starting with the `take` cycle. `gie_clr` is high in the `take` cycle. `push_lo` is high in the second cycle and `push_hi` in the third. The fourth cycle is the jump cycle, with no strobes.
- R10: `push_byte` carries bits 7:0 of `ret_addr`, sampled at the accepting boundary, while `push_lo` is high. It carries bits 15:8 while `push_hi` is high, and is zero otherwise.
- R11: In the `take` cycle, `ack` is one-hot on the winning source if that source's ACK_MASK bit is 1. It is all-zero if that bit is 0, which marks a source whose flag is cleared by software. `ack` is zero in every other cycle.
- R12: Boundaries and requests that arrive during an entry are ignored. A boundary in the cycle after `stall` falls can be accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | NUM_SRC | Pending request per source; bit 0 has the highest priority |
| gie | input | 1 | Current global interrupt-enable flag |
| insn_done | input | 1 | An instruction retires this cycle |
| insn_cls | input | 2 | Class of the retiring instruction: 0 plain, 1 set-enable, 2 return, 3 status store setting enable |
| ret_addr | input | 16 | Address of the next instruction, used as the return address |
| take | output | 1 | One-cycle pulse marking an accepted interrupt |
| vec_addr | output | VEC_W | Vector slot word address during entry |
| stall | output | 1 | Holds the core during entry |
| push_lo | output | 1 | Push strobe for the return-address low byte |
| push_hi | output | 1 | Push strobe for the return-address high byte |
| push_byte | output | 8 | Byte to push |
| gie_clr | output | 1 | Clears the global enable |
| ack | output | NUM_SRC | Acknowledge to the winning source |

## Verification
The bench builds the block with eight sources, a vector base of 0x0004 and two-word slots, so the vector arithmetic is visible away from address zero. It sets ACK_MASK to 0x5F, which leaves sources 5 and 7 without an acknowledge. With that setting the software-cleared case can be reached both for the lowest-priority source and for a source in the middle. Every enabling class is driven with a request already waiting. The bench also holds the retirement strobe high through a whole entry to exercise the ignore window.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
  localparam int RET_W  = 16;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    RC_PLAIN   = 2'd0,
    RC_SETIE   = 2'd1,
    RC_RETURN  = 2'd2,
    RC_SRWRITE = 2'd3
  } retire_cls_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_TAKE  = 3'd1,
    ST_PUSHL = 3'd2,
    ST_PUSHH = 3'd3,
    ST_JUMP  = 3'd4
  } entry_st_e;
endpackage

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int N     = 8,
  parameter int IDX_W = 3
) (
  input  logic [N-1:0]     req,
  output logic [N-1:0]     grant,
  output logic [IDX_W-1:0] idx,
  output logic             any
);
  // grant[i] is set when req[i] is set and no lower index requests
  for (genvar gi = 0; gi < N; gi++) begin : g_grant
    if (gi == 0) begin : g_first
      assign grant[gi] = req[gi];
    end else begin : g_rest
      assign grant[gi] = req[gi] & ~(|req[gi-1:0]);
    end
  end

  always_comb begin
    idx = '0;
    for (int i = 0; i < N; i++) begin
      if (grant[i]) idx = idx | IDX_W'(i);
    end
  end

  assign any = |req;
endmodule

// File: rtl/irq_vec_calc.sv
module irq_vec_calc #(
  parameter int                 IDX_W      = 3,
  parameter int                 VEC_W      = 16,
  parameter logic [VEC_W-1:0]   VEC_BASE   = 16'h0002,
  parameter int                 SLOT_WORDS = 2
) (
  input  logic [IDX_W-1:0] idx,
  output logic [VEC_W-1:0] vec
);
  localparam logic [VEC_W-1:0] SLOT = VEC_W'(SLOT_WORDS);

  assign vec = VEC_BASE + (VEC_W'(idx) * SLOT);
endmodule

// File: rtl/irq_entry_fsm.sv
module irq_entry_fsm
  import irq_seq_pkg::*;
#(
  parameter int             N        = 8,
  parameter int             VEC_W    = 16,
  parameter logic [N-1:0]   ACK_MASK = '1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               accept_ok,
  input  logic [N-1:0]       grant,
  input  logic [VEC_W-1:0]   vec_in,
  input  logic [RET_W-1:0]   ret_addr,
  output logic               take,
  output logic [VEC_W-1:0]   vec_addr,
  output logic               stall,
  output logic               push_lo,
  output logic               push_hi,
  output logic [BYTE_W-1:0]  push_byte,
  output logic               gie_clr,
  output logic [N-1:0]       ack
);
  entry_st_e        st_q;
  logic [RET_W-1:0] ret_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_IDLE;
      ret_q     <= '0;
      take      <= 1'b0;
      vec_addr  <= '0;
      stall     <= 1'b0;
      push_lo   <= 1'b0;
      push_hi   <= 1'b0;
      push_byte <= '0;
      gie_clr   <= 1'b0;
      ack       <= '0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (accept_ok) begin
            st_q     <= ST_TAKE;
            ret_q    <= ret_addr;
            take     <= 1'b1;
            gie_clr  <= 1'b1;
            ack      <= grant & ACK_MASK;
            vec_addr <= vec_in;
            stall    <= 1'b1;
          end
        end
        ST_TAKE: begin
          st_q      <= ST_PUSHL;
          take      <= 1'b0;
          gie_clr   <= 1'b0;
          ack       <= '0;
          push_lo   <= 1'b1;
          push_byte <= ret_q[BYTE_W-1:0];
        end
        ST_PUSHL: begin
          st_q      <= ST_PUSHH;
          push_lo   <= 1'b0;
          push_hi   <= 1'b1;
          push_byte <= ret_q[RET_W-1:BYTE_W];
        end
        ST_PUSHH: begin
          st_q      <= ST_JUMP;
          push_hi   <= 1'b0;
          push_byte <= '0;
        end
        default: begin
          st_q     <= ST_IDLE;
          stall    <= 1'b0;
          vec_addr <= '0;
        end
      endcase
    end
  end
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_seq_pkg::*;
#(
  parameter int                 NUM_SRC    = 8,
  parameter int                 VEC_W      = 16,
  parameter logic [VEC_W-1:0]   VEC_BASE   = 16'h0002,
  parameter int                 SLOT_WORDS = 2,
  parameter logic [NUM_SRC-1:0] ACK_MASK   = 8'h7F
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] irq_req,
  input  logic               gie,
  input  logic               insn_done,
  input  logic [1:0]         insn_cls,
  input  logic [15:0]        ret_addr,
  output logic               take,
  output logic [VEC_W-1:0]   vec_addr,
  output logic               stall,
  output logic               push_lo,
  output logic               push_hi,
  output logic [7:0]         push_byte,
  output logic               gie_clr,
  output logic [NUM_SRC-1:0] ack
);
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  logic [NUM_SRC-1:0] grant;
  logic [IDX_W-1:0]   win_idx;
  logic               any_req;
  logic [VEC_W-1:0]   win_vec;
  logic               plain_cls;
  logic               accept_ok;

  // Enabling classes open a one-instruction shadow: their own boundary is refused.
  assign plain_cls = (retire_cls_e'(insn_cls) == RC_PLAIN);
  assign accept_ok = insn_done & gie & plain_cls & any_req;

  irq_prio_enc #(.N(NUM_SRC), .IDX_W(IDX_W)) u_prio (
    .req   (irq_req),
    .grant (grant),
    .idx   (win_idx),
    .any   (any_req)
  );

  irq_vec_calc #(
    .IDX_W(IDX_W), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE), .SLOT_WORDS(SLOT_WORDS)
  ) u_vec (
    .idx (win_idx),
    .vec (win_vec)
  );

  irq_entry_fsm #(.N(NUM_SRC), .VEC_W(VEC_W), .ACK_MASK(ACK_MASK)) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .accept_ok (accept_ok),
    .grant     (grant),
    .vec_in    (win_vec),
    .ret_addr  (ret_addr),
    .take      (take),
    .vec_addr  (vec_addr),
    .stall     (stall),
    .push_lo   (push_lo),
    .push_hi   (push_hi),
    .push_byte (push_byte),
    .gie_clr   (gie_clr),
    .ack       (ack)
  );
endmodule

// File: rtl/irq_entry_chk.sv
module irq_entry_chk #(
  parameter int                 NUM_SRC  = 8,
  parameter int                 VEC_W    = 16,
  parameter logic [NUM_SRC-1:0] ACK_MASK = '1
) (
  input logic               clk,
  input logic               rst,
  input logic [NUM_SRC-1:0] irq_req,
  input logic               gie,
  input logic               insn_done,
  input logic [1:0]         insn_cls,
  input logic [15:0]        ret_addr,
  input logic               take,
  input logic [VEC_W-1:0]   vec_addr,
  input logic               stall,
  input logic               push_lo,
  input logic               push_hi,
  input logic [7:0]         push_byte,
  input logic               gie_clr,
  input logic [NUM_SRC-1:0] ack
);
  p_take_gated_r2: assert property (@(posedge clk) disable iff (rst)
    take |-> $past(insn_done && gie && insn_cls == 2'd0 && irq_req != '0 && !stall));

  p_shadow_sei_r3: assert property (@(posedge clk) disable iff (rst)
    (insn_done && insn_cls == 2'd1 && !stall) |=> !take);

  p_shadow_ret_r4: assert property (@(posedge clk) disable iff (rst)
    (insn_done && insn_cls == 2'd2 && !stall) |=> !take);

  p_shadow_sr_r5: assert property (@(posedge clk) disable iff (rst)
    (insn_done && insn_cls == 2'd3 && !stall) |=> !take);

  p_no_gie_r7: assert property (@(posedge clk) disable iff (rst)
    (!gie && !stall) |=> !take);

  p_vec_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (stall && !take) |-> $stable(vec_addr));

  p_take_seq_r9: assert property (@(posedge clk) disable iff (rst)
    take |-> (stall && gie_clr) ##1 push_lo ##1 push_hi ##1 (stall && !push_lo && !push_hi) ##1 !stall);

  p_lo_byte_r10: assert property (@(posedge clk) disable iff (rst)
    push_lo |-> push_byte == $past(ret_addr[7:0], 2));

  p_hi_byte_r10: assert property (@(posedge clk) disable iff (rst)
    push_hi |-> push_byte == $past(ret_addr[15:8], 3));

  p_ack_shape_r11: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ack) && ((ack & ~ACK_MASK) == '0) && (ack == '0 || take));

  p_no_retake_r12: assert property (@(posedge clk) disable iff (rst)
    take |-> !$past(stall));
endmodule

bind irq_entry_seq irq_entry_chk #(
  .NUM_SRC(NUM_SRC), .VEC_W(VEC_W), .ACK_MASK(ACK_MASK)
) u_chk (
  .clk(clk), .rst(rst), .irq_req(irq_req), .gie(gie), .insn_done(insn_done),
  .insn_cls(insn_cls), .ret_addr(ret_addr), .take(take), .vec_addr(vec_addr),
  .stall(stall), .push_lo(push_lo), .push_hi(push_hi), .push_byte(push_byte),
  .gie_clr(gie_clr), .ack(ack)
);

// File: tb/tb_irq_entry_seq.sv
module tb_irq_entry_seq;
  localparam int          N  = 8;
  localparam logic [15:0] VB = 16'h0004;
  localparam int          SW = 2;
  localparam logic [7:0]  AM = 8'h5F;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [N-1:0] irq_req = '0;
  logic        gie = 1'b0;
  logic        insn_done = 1'b0;
  logic [1:0]  insn_cls = 2'd0;
  logic [15:0] ret_addr = '0;
  logic        take, stall, push_lo, push_hi, gie_clr;
  logic [15:0] vec_addr;
  logic [7:0]  push_byte;
  logic [N-1:0] ack;

  always #4 clk = ~clk;

  irq_entry_seq #(
    .NUM_SRC(N), .VEC_W(16), .VEC_BASE(VB), .SLOT_WORDS(SW), .ACK_MASK(AM)
  ) dut (
    .clk(clk), .rst(rst), .irq_req(irq_req), .gie(gie), .insn_done(insn_done),
    .insn_cls(insn_cls), .ret_addr(ret_addr), .take(take), .vec_addr(vec_addr),
    .stall(stall), .push_lo(push_lo), .push_hi(push_hi), .push_byte(push_byte),
    .gie_clr(gie_clr), .ack(ack)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit cmp_en = 1'b0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference: entry cycle counter 0 (idle) .. 4
  int          m_cnt = 0;
  int          m_sel = 0;
  logic [15:0] m_pc  = '0;

  always @(posedge clk) begin
    if (rst) begin
      m_cnt = 0;
    end else if (m_cnt != 0) begin
      m_cnt = (m_cnt == 4) ? 0 : m_cnt + 1;
    end else if (insn_done && gie && insn_cls == 2'd0 && irq_req != '0) begin
      for (int i = N - 1; i >= 0; i--) if (irq_req[i]) m_sel = i;
      m_pc  = ret_addr;
      m_cnt = 1;
    end
  end

  always @(negedge clk) begin
    if (cmp_en) begin
      logic [15:0] e_vec;
      logic [7:0]  e_pb;
      logic [N-1:0] e_ack;
      e_vec = (m_cnt != 0) ? VB + 16'(m_sel * SW) : 16'h0;
      e_pb  = (m_cnt == 2) ? m_pc[7:0] : (m_cnt == 3) ? m_pc[15:8] : 8'h0;
      e_ack = (m_cnt == 1 && AM[m_sel]) ? N'(1 << m_sel) : '0;
      check("R2 take", 32'(take), 32'(m_cnt == 1));
      check("R8 vec_addr", 32'(vec_addr), 32'(e_vec));
      check("R9 stall", 32'(stall), 32'(m_cnt != 0));
      check("R9 gie_clr", 32'(gie_clr), 32'(m_cnt == 1));
      check("R9 push_lo", 32'(push_lo), 32'(m_cnt == 2));
      check("R9 push_hi", 32'(push_hi), 32'(m_cnt == 3));
      check("R10 push_byte", 32'(push_byte), 32'(e_pb));
      check("R11 ack", 32'(ack), 32'(e_ack));
    end
  end

  task automatic bnd(input logic [1:0] c, input logic [15:0] pc);
    @(negedge clk);
    insn_done = 1'b1; insn_cls = c; ret_addr = pc;
    @(negedge clk);
    insn_done = 1'b0; insn_cls = 2'd0;
  endtask

  task automatic entry_tail(input logic [15:0] pc);
    @(negedge clk);
    check("R9 lo strobe", 32'(push_lo), 32'd1);
    check("R10 lo byte", 32'(push_byte), 32'(pc[7:0]));
    @(negedge clk);
    check("R9 hi strobe", 32'(push_hi), 32'd1);
    check("R10 hi byte", 32'(push_byte), 32'(pc[15:8]));
    @(negedge clk);
    check("R9 jump cycle", 32'({stall, push_lo, push_hi}), 32'b100);
    @(negedge clk);
    check("R9 stall end", 32'(stall), 32'd0);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    #(8 * 20000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog (all requirements) actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    @(posedge clk);
    cmp_en = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 reset outputs", 32'({take, stall, push_lo, push_hi, gie_clr, push_byte, ack}), 32'd0);
    check("R1 reset vec", 32'(vec_addr), 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 after reset", 32'({take, stall}), 32'd0);

    // R2: plain boundary with enable on
    gie = 1'b1; irq_req = 8'h08;
    bnd(2'd0, 16'h1234);
    check("R2 accepted", 32'(take), 32'd1);
    check("R8 vector src3", 32'(vec_addr), 32'(VB + 16'd6));
    entry_tail(16'h1234);
    irq_req = '0;

    // R3: set-enable shadow
    irq_req = 8'h10;
    bnd(2'd1, 16'h0100);
    check("R3 shadow blocks", 32'(take), 32'd0);
    bnd(2'd0, 16'h0102);
    check("R3 next accepted", 32'(take), 32'd1);
    entry_tail(16'h0102);
    irq_req = '0;

    // R4: return shadow
    irq_req = 8'h02;
    bnd(2'd2, 16'h0200);
    check("R4 shadow blocks", 32'(take), 32'd0);
    bnd(2'd0, 16'h0201);
    check("R4 next accepted", 32'(take), 32'd1);
    entry_tail(16'h0201);
    irq_req = '0;

    // R5: status-store shadow
    irq_req = 8'h40;
    bnd(2'd3, 16'h0300);
    check("R5 shadow blocks", 32'(take), 32'd0);
    bnd(2'd0, 16'h0301);
    check("R5 next accepted", 32'(take), 32'd1);
    entry_tail(16'h0301);
    irq_req = '0;

    // R6: shadow restarts
    irq_req = 8'h01;
    bnd(2'd1, 16'h0400);
    check("R6 first blocks", 32'(take), 32'd0);
    bnd(2'd2, 16'h0401);
    check("R6 restart blocks", 32'(take), 32'd0);
    bnd(2'd0, 16'h0402);
    check("R6 then accepted", 32'(take), 32'd1);
    entry_tail(16'h0402);
    irq_req = '0;

    // R7: enable gating, no extra delay once on
    gie = 1'b0; irq_req = 8'h02;
    bnd(2'd0, 16'h0500);
    check("R7 gie off", 32'(take), 32'd0);
    gie = 1'b1;
    bnd(2'd0, 16'h0501);
    check("R7 no extra delay", 32'(take), 32'd1);
    entry_tail(16'h0501);
    irq_req = '0;

    // R8 / R11: priority and acknowledge
    irq_req = 8'hA4;
    bnd(2'd0, 16'hBEEF);
    check("R8 lowest wins", 32'(vec_addr), 32'(VB + 16'd4));
    check("R11 ack src2", 32'(ack), 32'h04);
    entry_tail(16'hBEEF);
    irq_req = 8'h80;
    bnd(2'd0, 16'h0600);
    check("R11 src7 taken", 32'(take), 32'd1);
    check("R11 src7 no ack", 32'(ack), 32'd0);
    entry_tail(16'h0600);
    irq_req = 8'h20;
    bnd(2'd0, 16'h0700);
    check("R11 src5 no ack", 32'(ack), 32'd0);
    entry_tail(16'h0700);
    irq_req = '0;

    // R12: boundaries during entry ignored
    irq_req = 8'h40;
    @(negedge clk);
    insn_done = 1'b1; insn_cls = 2'd0; ret_addr = 16'h0800;
    begin
      int takes = 0;
      repeat (5) begin
        @(negedge clk);
        if (take) takes++;
        irq_req = 8'h01;
      end
      insn_done = 1'b0;
      check("R12 single take", 32'(takes), 32'd1);
    end
    @(negedge clk);
    check("R12 idle after", 32'(stall), 32'd0);
    bnd(2'd0, 16'h0900);
    check("R12 accept after stall", 32'(take), 32'd1);
    check("R12 new winner", 32'(vec_addr), 32'(VB));
    entry_tail(16'h0900);
    irq_req = '0;

    repeat (2) @(negedge clk);
    summary();
    $finish;
  end
endmodule